// File: doc/BRIEF.md
# Counter Machine Executor

This block is a small sequential engine that runs a program of counter-machine steps against a bank of bounded natural-number registers. Four operations exist: add one to a register, subtract one from a register, branch on a zero register, and stop. The program sits in an internal instruction store that the host fills through a write port while the engine is not running. The register bank is preloaded and read back through a separate port. A start pulse launches execution from address 0. One instruction retires on every clock until the stop instruction or a fault ends the run.

Control is a three-state machine. `ST_IDLE` is entered from reset. `ST_RUN` is entered from `ST_IDLE` or `ST_HALTED` when `start` is high; the start transition loads the instruction pointer with 0 and clears both flags. `ST_HALTED` is entered from `ST_RUN` in three cases: a stop instruction retires, a taken branch names a target outside the program, or a sequential advance leaves the program. The loaded program length is one more than the highest instruction address written since reset. Registers saturate at both ends. A sticky flag records an increment that hit the top value, and a second flag records an out-of-program transfer.

Top module: `cm_exec`

## Requirements
- R1: After reset `halted`, `overflow` and `jump_err` are 0, `ip` is 0 and every register reads 0.
- R2: An instruction word (9 bits at default parameters) holds the opcode in bits [8:7] (00 increment, 01 decrement, 10 branch-if-zero, 11 stop), the register index in bits [6:4] and the branch target in bits [3:0].
- R3: Increment writes the register value plus one back to that register and advances `ip` by one.
- R4: Decrement writes the register value minus one back and advances `ip` by one; a register already at 0 stays at 0.
- R5: Branch-if-zero loads `ip` with the target when the named register holds 0 and otherwise advances `ip` by one; it changes no register.
- R6: Stop asserts `halted`. While no new start arrives, `ip` keeps the stop instruction's address and the registers keep their values.
- R7: Increment of a register at its maximum (255) leaves it at 255 and sets `overflow`; `overflow` stays set until the next start or reset.
- R8: A taken branch whose target is not below the loaded program length, or a sequential advance past the last loaded address, halts the machine with `jump_err` set and `ip` left on the offending instruction; an increment or decrement that advances past the end still updates its register.
- R9: A program of N instructions executed straight through, ending on stop, raises `halted` on the N-th clock edge after the edge that samples `start`.
- R10: While running, program writes, register preload writes and `start` have no effect. From `ST_HALTED`, `start` reruns the program from address 0 with `overflow` and `jump_err` cleared.
- R11: `reg_rdata` shows the register selected by `reg_addr` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured when not running |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 4 | Instruction store write address |
| prog_wdata | input | 9 | Instruction word to store |
| reg_we | input | 1 | Register preload write enable |
| reg_addr | input | 3 | Register preload / readback index |
| reg_wdata | input | 8 | Register preload value |
| reg_rdata | output | 8 | Readback of the indexed register |
| halted | output | 1 | Machine is in the halted state |
| overflow | output | 1 | Sticky saturating-increment flag |
| jump_err | output | 1 | Out-of-program transfer flag |
| ip | output | 4 | Current instruction pointer |

## Verification
Each retired instruction updates its register, `ip` and the flags on the same clock edge that executes it. A check made at the falling edge after edge k therefore sees the effect of the instruction that edge k retired, while readback through `reg_rdata` is due in the same cycle its address is applied. The bench counts falling edges from the start-sampling edge until `halted` rises and compares that count with the instruction count the program must retire. It then reads the registers and flags only after the halt, and reads them again some cycles later to show the halted state holds.

// File: rtl/cm_pkg.sv
package cm_pkg;

    typedef enum logic [1:0] {
        OP_INC  = 2'b00,
        OP_DEC  = 2'b01,
        OP_JZ   = 2'b10,
        OP_HALT = 2'b11
    } cm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_RUN    = 2'b01,
        ST_HALTED = 2'b10
    } cm_state_e;

endpackage

// File: rtl/cm_prog_rom.sv
module cm_prog_rom #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata,
    output logic [AW:0]      len
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      len_q;
    logic [AW:0]      waddr_p1;

    assign waddr_p1 = {1'b0, waddr} + (AW+1)'(1);

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Program length tracks the highest written address plus one
    always_ff @(posedge clk) begin
        if (!rst_n)                        len_q <= '0;
        else if (we && waddr_p1 > len_q)   len_q <= waddr_p1;
    end

    assign rdata = mem[raddr];
    assign len   = len_q;

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= (AW+1)'(DEPTH)); // R8

endmodule

// File: rtl/cm_reg_bank.sv
module cm_reg_bank #(
    parameter int REG_W    = 8,
    parameter int NUM_REGS = 8,
    parameter int RIDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [RIDX_W-1:0] load_idx,
    input  logic [REG_W-1:0]  load_val,
    input  logic [RIDX_W-1:0] rb_idx,
    output logic [REG_W-1:0]  rb_val,
    input  logic              exec_en,
    input  logic              exec_inc,
    input  logic [RIDX_W-1:0] exec_idx,
    output logic [REG_W-1:0]  exec_val,
    output logic              sat_hit
);

    localparam logic [REG_W-1:0] MAX_VAL = '1;

    logic [REG_W-1:0] regs [NUM_REGS];
    logic [REG_W-1:0] upd_val;

    assign exec_val = regs[exec_idx];
    assign rb_val   = regs[rb_idx];
    assign sat_hit  = exec_en && exec_inc && (exec_val == MAX_VAL);

    always_comb begin
        if (exec_inc) upd_val = (exec_val == MAX_VAL) ? exec_val : exec_val + REG_W'(1);
        else          upd_val = (exec_val == '0)      ? exec_val : exec_val - REG_W'(1);
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (exec_en && exec_idx == RIDX_W'(g))
                regs[g] <= upd_val;
            else if (load_en && load_idx == RIDX_W'(g))
                regs[g] <= load_val;
        end
    end

    AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !exec_inc && exec_val == '0) |=> regs[$past(exec_idx)] == '0); // R4

    AST_INC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && exec_inc && exec_val == MAX_VAL) |=> regs[$past(exec_idx)] == MAX_VAL); // R7

endmodule

// File: rtl/cm_exec.sv
module cm_exec
    import cm_pkg::*;
#(
    parameter  int REG_W      = 8,
    parameter  int NUM_REGS   = 8,
    parameter  int PROG_DEPTH = 16,
    localparam int RIDX_W     = $clog2(NUM_REGS),
    localparam int PC_W       = $clog2(PROG_DEPTH),
    localparam int INSTR_W    = 2 + RIDX_W + PC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [INSTR_W-1:0] prog_wdata,
    input  logic               reg_we,
    input  logic [RIDX_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               halted,
    output logic               overflow,
    output logic               jump_err,
    output logic [PC_W-1:0]    ip
);

    cm_state_e state_q, state_n;
    logic [PC_W-1:0]    ip_q, ip_n;
    logic               ovf_q, err_q, set_err;
    logic               exec_en, exec_inc, sat_hit, launch, running;
    logic [INSTR_W-1:0] instr;
    logic [PC_W:0]      prog_len;
    logic [REG_W-1:0]   exec_val;
    cm_op_e             op;
    logic [RIDX_W-1:0]  ridx;
    logic [PC_W-1:0]    tgt;
    logic               ip_bad, tgt_bad, seq_bad, cur_zero;

    assign running = (state_q == ST_RUN);
    assign launch  = start && !running;

    cm_prog_rom #(.DEPTH(PROG_DEPTH), .WIDTH(INSTR_W), .AW(PC_W)) u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prog_we && !running),
        .waddr (prog_addr),
        .wdata (prog_wdata),
        .raddr (ip_q),
        .rdata (instr),
        .len   (prog_len)
    );

    cm_reg_bank #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .RIDX_W(RIDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (reg_we && !running),
        .load_idx (reg_addr),
        .load_val (reg_wdata),
        .rb_idx   (reg_addr),
        .rb_val   (reg_rdata),
        .exec_en  (exec_en),
        .exec_inc (exec_inc),
        .exec_idx (ridx),
        .exec_val (exec_val),
        .sat_hit  (sat_hit)
    );

    // Instruction field decode
    assign op       = cm_op_e'(instr[INSTR_W-1 -: 2]);
    assign ridx     = instr[PC_W +: RIDX_W];
    assign tgt      = instr[PC_W-1:0];
    assign cur_zero = (exec_val == '0);
    assign ip_bad   = {1'b0, ip_q} >= prog_len;
    assign tgt_bad  = {1'b0, tgt}  >= prog_len;
    assign seq_bad  = ({1'b0, ip_q} + (PC_W+1)'(1)) >= prog_len;

    // Next-state and execute decisions
    always_comb begin
        state_n  = state_q;
        ip_n     = ip_q;
        set_err  = 1'b0;
        exec_en  = 1'b0;
        exec_inc = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_HALTED: begin
                if (start) begin
                    state_n = ST_RUN;
                    ip_n    = '0;
                end
            end
            ST_RUN: begin
                if (ip_bad) begin
                    state_n = ST_HALTED;
                    set_err = 1'b1;
                end else begin
                    unique case (op)
                        OP_INC, OP_DEC: begin
                            exec_en  = 1'b1;
                            exec_inc = (op == OP_INC);
                            if (seq_bad) begin
                                state_n = ST_HALTED;
                                set_err = 1'b1;
                            end else begin
                                ip_n = ip_q + PC_W'(1);
                            end
                        end
                        OP_JZ: begin
                            if (cur_zero) begin
                                if (tgt_bad) begin
                                    state_n = ST_HALTED;
                                    set_err = 1'b1;
                                end else begin
                                    ip_n = tgt;
                                end
                            end else if (seq_bad) begin
                                state_n = ST_HALTED;
                                set_err = 1'b1;
                            end else begin
                                ip_n = ip_q + PC_W'(1);
                            end
                        end
                        OP_HALT: state_n = ST_HALTED;
                        default: state_n = ST_HALTED;
                    endcase
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ip_q    <= '0;
        end else begin
            state_q <= state_n;
            ip_q    <= ip_n;
        end
    end

    // Flag and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else if (launch) begin
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (sat_hit) ovf_q <= 1'b1;
            if (set_err) err_q <= 1'b1;
        end
    end

    assign halted   = (state_q == ST_HALTED);
    assign overflow = ovf_q;
    assign jump_err = err_q;
    assign ip       = ip_q;

    AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> (halted && $stable(ip))); // R6

    AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ip_bad && op == OP_JZ && cur_zero && !tgt_bad) |=> ip == $past(tgt)); // R5

    AST_ERR_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        jump_err |-> !running); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !launch) |=> overflow); // R7

endmodule

// File: tb/cm_exec_tb_top.sv
module cm_exec_tb_top;

    localparam int RW = 8;
    localparam int IW = 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          prog_we;
    logic [3:0]    prog_addr;
    logic [IW-1:0] prog_wdata;
    logic          reg_we;
    logic [2:0]    reg_addr;
    logic [RW-1:0] reg_wdata;
    logic [RW-1:0] reg_rdata;
    logic          halted, overflow, jump_err;
    logic [3:0]    ip;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    cm_exec dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .halted(halted), .overflow(overflow),
        .jump_err(jump_err), .ip(ip)
    );

    // Encoding per R2: opcode [8:7], register [6:4], target [3:0]
    localparam logic [1:0] C_INC = 2'b00, C_DEC = 2'b01, C_JZ = 2'b10, C_HALT = 2'b11;

    function automatic logic [IW-1:0] enc(logic [1:0] o, int r, int t);
        return {o, 3'(r), 4'(t)};
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; prog_we = 1'b0; reg_we = 1'b0;
        prog_addr = '0; prog_wdata = '0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(int a, logic [1:0] o, int r, int t);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = 4'(a); prog_wdata = enc(o, r, t);
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic preload(int r, int v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(r); reg_wdata = RW'(v);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_reg(int r, output int v);
        reg_addr = 3'(r);
        #1;
        v = int'(reg_rdata);
    endtask

    // Pulse start; count falling edges until halted (each follows one rising edge)
    task automatic run(output int n);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        @(negedge clk);
        chk("R1 halted", int'(halted), 0);
        chk("R1 ip", int'(ip), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 jump_err", int'(jump_err), 0);
        read_reg(0, v); chk("R1 reg0", v, 0);
        read_reg(7, v); chk("R1 reg7", v, 0);
    endtask

    task automatic t_inc_dec_halt();
        int n, v;
        do_reset();
        load(0, C_INC, 1, 0);
        load(1, C_INC, 1, 0);
        load(2, C_DEC, 2, 0);
        load(3, C_HALT, 0, 0);
        preload(2, 5);
        read_reg(2, v); chk("R11 readback", v, 5);
        run(n);
        chk("R9 cycles to halt", n, 4);
        chk("R6 ip on stop", int'(ip), 3);
        read_reg(1, v); chk("R3 inc twice", v, 2);
        read_reg(2, v); chk("R4 dec", v, 4);
        chk("R2 no error", int'(jump_err), 0);
        repeat (3) @(negedge clk);
        chk("R6 halted holds", int'(halted), 1);
        chk("R6 ip holds", int'(ip), 3);
        read_reg(1, v); chk("R6 reg holds", v, 2);
    endtask

    task automatic t_dec_floor();
        int n, v;
        do_reset();
        load(0, C_DEC, 3, 0);
        load(1, C_HALT, 0, 0);
        run(n);
        read_reg(3, v); chk("R4 floor at zero", v, 0);
        chk("R4 no overflow", int'(overflow), 0);
    endtask

    task automatic t_jz_loop();
        int n, v;
        do_reset();
        load(0, C_JZ, 1, 4);
        load(1, C_DEC, 1, 0);
        load(2, C_INC, 2, 0);
        load(3, C_JZ, 0, 0);
        load(4, C_HALT, 0, 0);
        preload(1, 3);
        run(n);
        chk("R5 loop cycles", n, 14);
        chk("R5 taken branch ip", int'(ip), 4);
        read_reg(1, v); chk("R5 source drained", v, 0);
        read_reg(2, v); chk("R5 dest count", v, 3);
        read_reg(0, v); chk("R5 branch reg untouched", v, 0);
        chk("R5 no error", int'(jump_err), 0);
    endtask

    task automatic t_saturate();
        int n, v;
        do_reset();
        load(0, C_INC, 4, 0);
        load(1, C_INC, 4, 0);
        load(2, C_INC, 4, 0);
        load(3, C_HALT, 0, 0);
        preload(4, 254);
        run(n);
        read_reg(4, v); chk("R7 saturated", v, 255);
        chk("R7 overflow set", int'(overflow), 1);
        repeat (4) @(negedge clk);
        chk("R7 overflow sticky", int'(overflow), 1);
        preload(4, 0);
        run(n);
        read_reg(4, v); chk("R10 rerun from zero", v, 3);
        chk("R10 overflow cleared on start", int'(overflow), 0);
        chk("R10 rerun halts", int'(halted), 1);
    endtask

    task automatic t_jump_err();
        int n, v;
        do_reset();
        load(0, C_JZ, 0, 9);
        load(1, C_HALT, 0, 0);
        run(n);
        chk("R8 bad target halts", int'(halted), 1);
        chk("R8 bad target error", int'(jump_err), 1);
        chk("R8 ip on offender", int'(ip), 0);
        do_reset();
        load(0, C_INC, 5, 0);
        run(n);
        chk("R8 fall-off error", int'(jump_err), 1);
        chk("R8 fall-off ip", int'(ip), 0);
        read_reg(5, v); chk("R8 fall-off reg updated", v, 1);
    endtask

    task automatic t_run_writes_ignored();
        int n, v;
        do_reset();
        load(0, C_JZ, 1, 3);
        load(1, C_DEC, 1, 0);
        load(2, C_JZ, 0, 0);
        load(3, C_HALT, 0, 0);
        preload(1, 10);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 8'd77;
        prog_we = 1'b1; prog_addr = 4'd3; prog_wdata = enc(C_INC, 6, 0);
        start = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; prog_we = 1'b0; start = 1'b0;
        n = 2;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R10 start ignored while running", n, 32);
        chk("R10 prog write ignored", int'(ip), 3);
        chk("R10 no error", int'(jump_err), 0);
        read_reg(6, v); chk("R10 preload ignored", v, 0);
        read_reg(1, v); chk("R10 counter drained", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_inc_dec_halt();
        t_dec_floor();
        t_jz_loop();
        t_saturate();
        t_jump_err();
        t_run_writes_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule